// File: doc/BRIEF.md
# Lane State Sequencer

The block is a small programmable sequencer that sets the state of a serial display link's lanes over time. Software loads up to sixteen slot descriptors, each naming a lane mode, an escape-entry code, a packet source, a clock-lane enable and four data-lane enables. It also loads a successor table that gives the next slot for every slot, and one counted-jump descriptor. Writing the run bit then launches the walk.

The walk always begins at slot 0. It moves from slot to slot when the lane layer reports `slot_done`, so every slot lasts at least one cycle. Slot 15 is the terminator: stepping onto it ends the walk and clears the run bit, which software can poll. The counted jump replaces the table's successor of one chosen slot with a chosen target, for as many departures as the programmed count allows. After that the table applies again. Writing the run bit low stops a walk at once. The current slot and a busy flag come out as plain status pins. The link has no streaming data path, so the block has no valid/ready interface. All pins are plain control and status.

Top module: `lane_seq_engine`

## Requirements
- R1: After reset `busy` is 0, `cur_slot` is 0, every lane output is 0 and every register reads 0.
- R2: Word addresses are: 0 is the control word (run bit in bit 0), 1 is the successor table, 2 is the jump descriptor, and 16+k is slot k's descriptor. A write when idle is read back unchanged. Any other address reads 0.
- R3: A control write with bit 0 set while idle makes `busy` 1 and `cur_slot` 0 in the next cycle, and the control word then reads 1.
- R4: While busy, a cycle with `slot_done` high moves `cur_slot` to its successor in the next cycle. The successor of slot k is table bits [4k+3:4k]. Without `slot_done`, `cur_slot` holds.
- R5: While busy, `lane_mode`, `esc_code`, `pkt_src`, `clk_lane_en` and `data_lane_en` equal the current slot's descriptor bits 31:28, 27:24, 23:20, 4 and 3:0. While idle they are all 0. Mode 0 is stop, and packet source 0 is pixel data and 1 is command data.
- R6: The jump descriptor holds a jump slot in bits 19:16, a target in bits 23:20 and a count in bits 15:0. Leaving the jump slot while the remaining count is non-zero goes to the target and lowers the count by one. At zero the table applies. The count reloads at every start.
- R7: Advancing onto slot 15, whether from the table or from the jump, ends the walk. In the next cycle `busy` is 0, `cur_slot` is 15 and the control word reads 0.
- R8: A control write with bit 0 clear while busy returns the engine to idle in the next cycle, and `cur_slot` holds its value.
- R9: While busy, writes to the table, the jump descriptor or slot descriptors are ignored. A control write with bit 0 set neither restarts nor moves the walk.
- R10: While idle, `slot_done` has no effect on `cur_slot` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| slot_done | input | 1 | Lane layer finished the current slot |
| busy | output | 1 | Walk in progress (mirrors the run bit) |
| cur_slot | output | 4 | Slot being executed |
| lane_mode | output | 4 | Lane mode of the current slot |
| esc_code | output | 4 | Escape-entry code of the current slot |
| pkt_src | output | 4 | Packet source of the current slot |
| clk_lane_en | output | 1 | Clock-lane enable of the current slot |
| data_lane_en | output | 4 | Data-lane enables of the current slot |

## Verification
The assertions check the rules that hold on every cycle: the lanes are quiet when idle, the slot holds without `slot_done`, nothing moves while idle, a start lands on slot 0, an abort idles the engine, and the engine is never busy while sitting on slot 15. Only the bench scenarios can show that the visited order matches the programmed table. They also show the jump being taken exactly as many times as the count allows and the count reloading on a restart. They show that writes made during a walk leave the configuration untouched, by reading it back, and the bench compares every cycle of randomized chains against its own model of the walk.

// File: rtl/lse_pkg.sv
package lse_pkg;

  localparam int WORD_W   = 32;
  localparam int PTR_W    = 4;
  localparam int END_SLOT = 15;

  // Lane mode encodings (0 is stop)
  localparam logic [3:0] MODE_STOP = 4'd0;
  localparam logic [3:0] MODE_HS   = 4'd1;
  localparam logic [3:0] MODE_ESC  = 4'd2;
  localparam logic [3:0] MODE_TURN = 4'd3;
  localparam logic [3:0] MODE_HSCX = 4'd4;
  localparam logic [3:0] MODE_NOP  = 4'd5;

  // Packet source encodings
  localparam logic [3:0] SRC_PIXEL = 4'd0;
  localparam logic [3:0] SRC_CMD   = 4'd1;

  // Decoded lane fields of one slot descriptor
  typedef struct packed {
    logic [3:0] mode;
    logic [3:0] esc;
    logic [3:0] src;
    logic       clk_en;
    logic [3:0] data_en;
  } lane_cfg_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  function automatic lane_cfg_t unpack_slot(input logic [WORD_W-1:0] w);
    lane_cfg_t c;
    c.mode    = w[31:28];
    c.esc     = w[27:24];
    c.src     = w[23:20];
    c.clk_en  = w[4];
    c.data_en = w[3:0];
    return c;
  endfunction

endpackage

// File: rtl/lse_regs.sv
module lse_regs
  import lse_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SLOTS  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                locked,
  input  logic                run_flag,
  output lane_cfg_t           slot_cfg [SLOTS],
  output logic [WORD_W-1:0]   chain_word,
  output logic [PTR_W-1:0]    jmp_point,
  output logic [PTR_W-1:0]    jmp_target,
  output logic [CNT_W-1:0]    jmp_count,
  output logic [WORD_W-1:0]   rdata
);

  localparam int SLOT_BASE  = SLOTS;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CHAIN = 1;
  localparam int ADDR_JUMP  = 2;

  logic [WORD_W-1:0] slot_word [SLOTS];
  logic [WORD_W-1:0] jump_word;
  logic [SLOTS-1:0]  slot_hit;
  logic              wr_ok;

  assign wr_ok = cfg_wr && !locked;

  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign slot_hit[k] = (addr == ADDR_W'(SLOT_BASE + k));
      assign slot_cfg[k] = unpack_slot(slot_word[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) slot_word[k] <= '0;
      chain_word <= '0;
      jump_word  <= '0;
    end else if (wr_ok) begin
      for (int k = 0; k < SLOTS; k++)
        if (slot_hit[k]) slot_word[k] <= wdata;
      if (addr == ADDR_W'(ADDR_CHAIN)) chain_word <= wdata;
      if (addr == ADDR_W'(ADDR_JUMP))  jump_word  <= wdata;
    end
  end

  assign jmp_point  = jump_word[19:16];
  assign jmp_target = jump_word[23:20];
  assign jmp_count  = jump_word[CNT_W-1:0];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_CTRL))  rdata = {{(WORD_W-1){1'b0}}, run_flag};
    if (addr == ADDR_W'(ADDR_CHAIN)) rdata = chain_word;
    if (addr == ADDR_W'(ADDR_JUMP))  rdata = jump_word;
    for (int k = 0; k < SLOTS; k++)
      if (slot_hit[k]) rdata = slot_word[k];
  end

endmodule

// File: rtl/lse_next.sv
module lse_next
  import lse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [PTR_W-1:0]  cur,
  input  logic [CNT_W-1:0]  remaining,
  input  logic [WORD_W-1:0] chain_word,
  input  logic [PTR_W-1:0]  jmp_point,
  input  logic [PTR_W-1:0]  jmp_target,
  output logic [PTR_W-1:0]  nxt,
  output logic              take_jump
);

  logic [PTR_W-1:0] table_succ;

  assign table_succ = chain_word[{cur, 2'b00} +: PTR_W];
  assign take_jump  = (cur == jmp_point) && (remaining != '0);
  assign nxt        = take_jump ? jmp_target : table_succ;

endmodule

// File: rtl/lse_ctrl.sv
module lse_ctrl
  import lse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              slot_done,
  input  logic [PTR_W-1:0]  nxt,
  input  logic              take_jump,
  input  logic [CNT_W-1:0]  reload,
  output logic              busy,
  output logic [PTR_W-1:0]  cur,
  output logic [CNT_W-1:0]  remaining
);

  seq_state_e state;

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      remaining <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            state     <= ST_RUN;
            cur       <= '0;
            remaining <= reload;
          end
        end
        ST_RUN: begin
          if (stop_req) begin
            state <= ST_IDLE;
          end else if (slot_done) begin
            cur <= nxt;
            if (take_jump) remaining <= remaining - 1'b1;
            if (nxt == PTR_W'(END_SLOT)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_seq_engine.sv
module lane_seq_engine
  import lse_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SLOTS  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              slot_done,
  output logic              busy,
  output logic [3:0]        cur_slot,
  output logic [3:0]        lane_mode,
  output logic [3:0]        esc_code,
  output logic [3:0]        pkt_src,
  output logic              clk_lane_en,
  output logic [3:0]        data_lane_en
);

  lane_cfg_t         slot_cfg [SLOTS];
  lane_cfg_t         active;
  logic [WORD_W-1:0] chain_word;
  logic [PTR_W-1:0]  jmp_point, jmp_target, nxt;
  logic [CNT_W-1:0]  jmp_count, remaining;
  logic              take_jump, ctrl_hit, start_req, stop_req;

  assign ctrl_hit  = bus_wr && (bus_addr == '0);
  assign start_req = ctrl_hit && bus_wdata[0];
  assign stop_req  = ctrl_hit && !bus_wdata[0];

  lse_regs #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .locked    (busy),
    .run_flag  (busy),
    .slot_cfg  (slot_cfg),
    .chain_word(chain_word),
    .jmp_point (jmp_point),
    .jmp_target(jmp_target),
    .jmp_count (jmp_count),
    .rdata     (bus_rdata)
  );

  lse_next #(.CNT_W(CNT_W)) u_next (
    .cur       (cur_slot),
    .remaining (remaining),
    .chain_word(chain_word),
    .jmp_point (jmp_point),
    .jmp_target(jmp_target),
    .nxt       (nxt),
    .take_jump (take_jump)
  );

  lse_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .stop_req (stop_req),
    .slot_done(slot_done),
    .nxt      (nxt),
    .take_jump(take_jump),
    .reload   (jmp_count),
    .busy     (busy),
    .cur      (cur_slot),
    .remaining(remaining)
  );

  always_comb begin
    active = '0;
    if (busy) active = slot_cfg[cur_slot];
  end

  assign lane_mode    = active.mode;
  assign esc_code     = active.esc;
  assign pkt_src      = active.src;
  assign clk_lane_en  = active.clk_en;
  assign data_lane_en = active.data_en;

endmodule

// File: rtl/lse_checker.sv
module lse_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              slot_done,
  input logic              busy,
  input logic [3:0]        cur_slot,
  input logic [3:0]        lane_mode,
  input logic [3:0]        esc_code,
  input logic [3:0]        pkt_src,
  input logic              clk_lane_en,
  input logic [3:0]        data_lane_en
);

  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == '0);

  AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_mode == 4'd0 && esc_code == 4'd0 && pkt_src == 4'd0 && !clk_lane_en && data_lane_en == 4'd0)); // R5

  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_done && !ctrl_wr) |=> $stable(cur_slot)); // R4

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(ctrl_wr && bus_wdata[0])) |=> (!busy && $stable(cur_slot))); // R10

  AST_NEVER_BUSY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_slot != 4'hF)); // R7

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_wr && bus_wdata[0]) |=> (busy && cur_slot == 4'd0)); // R3

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && !bus_wdata[0]) |=> (!busy && $stable(cur_slot))); // R8

endmodule

bind lane_seq_engine lse_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .slot_done   (slot_done),
  .busy        (busy),
  .cur_slot    (cur_slot),
  .lane_mode   (lane_mode),
  .esc_code    (esc_code),
  .pkt_src     (pkt_src),
  .clk_lane_en (clk_lane_en),
  .data_lane_en(data_lane_en)
);

// File: tb/sim_lane_seq_engine.sv
`timescale 1ns/1ps
module sim_lane_seq_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slot_done = 1'b0;
  logic        busy;
  logic [3:0]  cur_slot, lane_mode, esc_code, pkt_src, data_lane_en;
  logic        clk_lane_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  lane_seq_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_done(slot_done),
    .busy(busy), .cur_slot(cur_slot), .lane_mode(lane_mode),
    .esc_code(esc_code), .pkt_src(pkt_src), .clk_lane_en(clk_lane_en),
    .data_lane_en(data_lane_en)
  );

  // Bench model of the requirements
  logic [31:0] m_slot [16];
  logic [31:0] m_chain, m_jump;
  logic        m_busy;
  logic [3:0]  m_cur;
  logic [15:0] m_cnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [5:0] a);
    if (a == 6'd0) return {31'b0, m_busy};
    if (a == 6'd1) return m_chain;
    if (a == 6'd2) return m_jump;
    if (a >= 6'd16) return m_slot[a - 6'd16];
    return 32'h0;
  endfunction

  function automatic logic [16:0] lanes_model();
    logic [31:0] w;
    w = m_busy ? m_slot[m_cur] : 32'h0;
    return {w[31:28], w[27:24], w[23:20], w[4], w[3:0]};
  endfunction

  task automatic model_step(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic done);
    logic [3:0] nx;
    logic       jmp;
    if (!m_busy) begin
      if (wr && a == 6'd0 && d[0]) begin
        m_busy = 1'b1; m_cur = 4'd0; m_cnt = m_jump[15:0];
      end else if (wr && a == 6'd1) m_chain = d;
      else if (wr && a == 6'd2) m_jump = d;
      else if (wr && a >= 6'd16) m_slot[a - 6'd16] = d;
    end else begin
      if (wr && a == 6'd0 && !d[0]) m_busy = 1'b0;
      else if (done) begin
        jmp = (m_cur == m_jump[19:16]) && (m_cnt != 16'd0);
        nx  = jmp ? m_jump[23:20] : m_chain[{m_cur, 2'b00} +: 4];
        if (jmp) m_cnt = m_cnt - 16'd1;
        m_cur = nx;
        if (nx == 4'hF) m_busy = 1'b0;
      end
    end
  endtask

  // One clock: apply inputs, update model, sample after the edge
  task automatic cyc(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic done);
    bus_wr = wr; bus_addr = a; bus_wdata = d; slot_done = done;
    model_step(wr, a, d, done);
    @(posedge clk); #1;
    bus_wr = 1'b0; slot_done = 1'b0;
    chk("R7 busy", {31'b0, busy}, {31'b0, m_busy});
    chk("R4 cur_slot", {28'b0, cur_slot}, {28'b0, m_cur});
    chk("R5 lanes", {15'b0, lane_mode, esc_code, pkt_src, clk_lane_en, data_lane_en},
        {15'b0, lanes_model()});
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    bus_addr = a; #1;
    chk(req, bus_rdata, rd_model(a));
  endtask

  task automatic idle(); cyc(1'b0, 6'd0, 32'h0, 1'b0); endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d); cyc(1'b1, a, d, 1'b0); endtask
  task automatic step(); cyc(1'b0, 6'd0, 32'h0, 1'b1); endtask

  initial begin
    for (int k = 0; k < 16; k++) m_slot[k] = '0;
    m_chain = '0; m_jump = '0; m_busy = 0; m_cur = 0; m_cnt = 0;
    void'($urandom(32'd4417));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 cur_slot", {28'b0, cur_slot}, 32'd0);
    chk("R1 lanes", {15'b0, lane_mode, esc_code, pkt_src, clk_lane_en, data_lane_en}, 32'd0);
    bus_addr = 6'd0;  #1 chk("R1 ctrl", bus_rdata, 32'd0);
    bus_addr = 6'd1;  #1 chk("R1 chain", bus_rdata, 32'd0);
    bus_addr = 6'd2;  #1 chk("R1 jump", bus_rdata, 32'd0);
    bus_addr = 6'd31; #1 chk("R1 slot15", bus_rdata, 32'd0);
    @(negedge clk);

    // R2: directed configuration and readback
    wr(6'd16, 32'h0000_001F);
    wr(6'd19, 32'h1010_0010);
    wr(6'd21, 32'h2510_0001);
    wr(6'd1,  32'hFFFF_5FF3);
    wr(6'd2,  32'h0003_0002);
    bus_addr = 6'd19; #1 chk("R2 slot3", bus_rdata, 32'h1010_0010);
    bus_addr = 6'd1;  #1 chk("R2 chain", bus_rdata, 32'hFFFF_5FF3);
    bus_addr = 6'd2;  #1 chk("R2 jump", bus_rdata, 32'h0003_0002);
    bus_addr = 6'd3;  #1 chk("R2 unmapped 3", bus_rdata, 32'h0);
    bus_addr = 6'd40; #1 chk("R2 unmapped 40", bus_rdata, 32'h0);

    // R3 start, R4 hold, R5 lanes, R6 jump twice, R7 end
    for (int pass = 0; pass < 2; pass++) begin
      wr(6'd0, 32'h1);
      chk("R3 start busy", {31'b0, busy}, 32'd1);
      chk("R3 start slot0", {28'b0, cur_slot}, 32'd0);
      rd("R3 ctrl reads 1", 6'd0);
      chk("R5 slot0 stop lanes", {27'b0, clk_lane_en, data_lane_en}, 32'h1F);
      idle(); idle();
      chk("R4 hold no done", {28'b0, cur_slot}, 32'd0);
      step(); chk("R4 0->3", {28'b0, cur_slot}, 32'd3);
      chk("R5 slot3 mode", {28'b0, lane_mode}, 32'd1);
      step(); chk("R6 jump 1 (pass reload)", {28'b0, cur_slot}, 32'd0);
      step(); chk("R4 0->3 again", {28'b0, cur_slot}, 32'd3);
      step(); chk("R6 jump 2", {28'b0, cur_slot}, 32'd0);
      step(); step(); chk("R6 count spent", {28'b0, cur_slot}, 32'd5);
      chk("R5 slot5 esc", {28'b0, esc_code}, 32'd5);
      step();
      chk("R7 end idle", {31'b0, busy}, 32'd0);
      chk("R7 end slot", {28'b0, cur_slot}, 32'd15);
      rd("R7 ctrl reads 0", 6'd0);
    end

    // R9: writes during a walk are ignored
    wr(6'd0, 32'h1); step();
    wr(6'd1, 32'h1234_5678);
    wr(6'd20, 32'hDEAD_BEEF);
    wr(6'd0, 32'h1);
    chk("R9 no restart", {28'b0, cur_slot}, 32'd3);
    bus_addr = 6'd1;  #1 chk("R9 chain kept", bus_rdata, 32'hFFFF_5FF3);
    bus_addr = 6'd20; #1 chk("R9 slot4 kept", bus_rdata, 32'h0);

    // R8: abort
    wr(6'd0, 32'h0);
    chk("R8 abort idle", {31'b0, busy}, 32'd0);
    chk("R8 abort slot held", {28'b0, cur_slot}, 32'd3);

    // R10: done while idle
    step(); step();
    chk("R10 idle done", {28'b0, cur_slot}, 32'd3);
    chk("R10 idle busy", {31'b0, busy}, 32'd0);

    // R6/R7: jump target is the end slot
    wr(6'd2, 32'h00F0_0001);
    wr(6'd0, 32'h1); step();
    chk("R7 jump to end", {31'b0, busy}, 32'd0);
    chk("R6 jump to end slot", {28'b0, cur_slot}, 32'd15);

    // Random chains checked against the model
    for (int t = 0; t < 25; t++) begin
      for (int k = 0; k < 16; k++) wr(6'(16 + k), $urandom);
      wr(6'd1, $urandom);
      wr(6'd2, {8'h0, 4'($urandom), 4'($urandom), 16'($urandom % 4)});
      rd("R2 random chain", 6'd1);
      rd("R2 random slot", 6'(16 + ($urandom % 16)));
      wr(6'd0, 32'h1);
      for (int c = 0; c < 40; c++) cyc(1'b0, 6'd0, 32'h0, 1'($urandom % 2));
      if (m_busy) begin
        wr(6'd0, 32'h0);
        chk("R8 random abort", {31'b0, busy}, 32'd0);
      end
      rd("R7 ctrl after walk", 6'd0);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule